// File: doc/BRIEF.md
# Software write-protect sequence guard

The block sits between a parallel byte-wide EEPROM's write port and its array. It receives one strobe for each completed byte write, with the full address and the data byte. It keeps one software protect flag for each 32 KB block of the address space. It decides, in the same cycle as the strobe, whether the array may really store that byte. Writes to a protected block are refused but still start the programming timer, so the caller sees a normal write period with no change to the array.

Two exact multi-write command sequences change the flags. Only the low fifteen address bits are compared against the command addresses. The upper two bits (16:15) of the final command byte select the block.
- The three-byte protect sequence also opens a write window for that block.
- The six-byte release sequence clears the block's flag.

The new flag value is applied when the write period ends, reported by `cycle_done`. This happens even if no data byte follows the sequence. A normal reset clears only the sequence tracking state. The flags are cleared only through the factory-initialise input.

Top module: `wpg_cmd_guard`

## Requirements
- R1: The write sequence AA to low address 5555, then 55 to 2AAA, then A0 to 5555 sets the flag of block `wr_addr[16:15]` (taken from the third write) on the first `cycle_done` after it. The flag is visible in `prot_flags` the cycle after that `cycle_done`. Only `wr_addr[14:0]` is compared with the command addresses.
- R2: The six-write sequence AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 clears the flag of block `wr_addr[16:15]` of its last write on the next `cycle_done`.
- R3: A write that matches the next expected command byte is a sequence byte, and `commit` is 0 for it.
- R4: After either sequence completes, writes to that sequence's block commit until the next `cycle_done`, even when the block is protected.
- R5: Every other write (not a sequence byte) commits when its block's flag is 0 or its block's window is open. Otherwise it gives `commit`=0 and `timer_only`=1. `commit` and `timer_only` are never both 1.
- R6: The last byte of either sequence asserts `timer_only`, so the write period runs and the flag change happens with no following data byte.
- R7: A write that does not match the next expected command byte returns the tracker to idle and is handled as an ordinary write. If that write is AA@5555, it begins a new sequence as its first byte instead.
- R8: Each block's flag is independent. A sequence or write aimed at one block leaves the other flags and their write decisions unchanged.
- R9: `prot_flags` is cleared only by `factory_init`, one cycle later. `rst_n` clears a partly matched sequence and a pending flag change but never the flags.
- R10: `commit` and `timer_only` are combinational from `wr_valid`, `wr_addr` and `wr_data` in the strobe cycle. They are 0 when `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequence tracker and the pending change |
| factory_init | input | 1 | Synchronous clear of all protect flags |
| wr_valid | input | 1 | One-cycle strobe for a completed byte write |
| wr_addr | input | 17 | Byte address; bits 16:15 select the block |
| wr_data | input | 8 | Written data byte |
| cycle_done | input | 1 | End of the current write period |
| commit | output | 1 | The array may store this byte |
| timer_only | output | 1 | Start the write timer without storing |
| prot_flags | output | 4 | Protect flag for each block |

## Verification
The bench runs several patterns, and each one separates a different fault:
- Complete protect and release sequences aimed at different blocks show that the flags stay independent and take effect only at `cycle_done`.
- A protect sequence with no data byte checks the empty-window case.
- A data byte after a sequence, sent to a protected block, checks the write window.
- Sequences broken by a foreign byte, and by a repeated lead byte, show a tracker that drops back to idle apart from one that stalls or skips a step.
- A reset in the middle of a sequence, followed by a factory clear, shows which state each of the two inputs owns.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int LOW_W = 15;
  localparam logic [LOW_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [LOW_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] K_LEAD     = 8'hAA;
  localparam logic [7:0] K_SECOND   = 8'h55;
  localparam logic [7:0] K_PROTECT  = 8'hA0;
  localparam logic [7:0] K_REL_PRE  = 8'h80;
  localparam logic [7:0] K_RELEASE  = 8'h20;

  typedef enum logic [2:0] {
    M_IDLE, M_LEAD, M_SECOND, M_REL_PRE, M_REL_LEAD, M_REL_SECOND
  } match_t;

  function automatic logic key_hit(input logic [LOW_W-1:0] lo, input logic [7:0] d,
                                   input logic [LOW_W-1:0] ka, input logic [7:0] kd);
    return (lo == ka) && (d == kd);
  endfunction
endpackage

// File: rtl/wpg_matcher.sv
module wpg_matcher
  import wpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [LOW_W-1:0] wr_lo,
  input  logic [7:0]       wr_data,
  output logic             seq_byte,
  output logic             fin_protect,
  output logic             fin_release
);
  match_t state, nxt;
  logic   adv;

  always_comb begin
    nxt = state;
    adv = 1'b0;
    fin_protect = 1'b0;
    fin_release = 1'b0;
    if (wr_valid) begin
      case (state)
        M_IDLE:       if (key_hit(wr_lo, wr_data, KEY_ADDR_A, K_LEAD))   begin nxt = M_LEAD;       adv = 1'b1; end
        M_LEAD:       if (key_hit(wr_lo, wr_data, KEY_ADDR_B, K_SECOND)) begin nxt = M_SECOND;     adv = 1'b1; end
        M_SECOND: begin
          if (key_hit(wr_lo, wr_data, KEY_ADDR_A, K_PROTECT)) begin
            nxt = M_IDLE; adv = 1'b1; fin_protect = 1'b1;
          end else if (key_hit(wr_lo, wr_data, KEY_ADDR_A, K_REL_PRE)) begin
            nxt = M_REL_PRE; adv = 1'b1;
          end
        end
        M_REL_PRE:    if (key_hit(wr_lo, wr_data, KEY_ADDR_A, K_LEAD))   begin nxt = M_REL_LEAD;   adv = 1'b1; end
        M_REL_LEAD:   if (key_hit(wr_lo, wr_data, KEY_ADDR_B, K_SECOND)) begin nxt = M_REL_SECOND; adv = 1'b1; end
        M_REL_SECOND: if (key_hit(wr_lo, wr_data, KEY_ADDR_A, K_RELEASE)) begin
          nxt = M_IDLE; adv = 1'b1; fin_release = 1'b1;
        end
        default: nxt = M_IDLE;
      endcase
      // R7: a broken sequence drops to idle, or restarts on a lead byte
      if (!adv) begin
        if (key_hit(wr_lo, wr_data, KEY_ADDR_A, K_LEAD)) begin
          nxt = M_LEAD; adv = 1'b1;
        end else begin
          nxt = M_IDLE;
        end
      end
    end
  end

  assign seq_byte = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= M_IDLE;
    else        state <= nxt;
  end

  assert_idle_after_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_protect || fin_release) |=> (state == M_IDLE));

  assert_lead_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && key_hit(wr_lo, wr_data, KEY_ADDR_A, K_LEAD) && state != M_REL_PRE)
      |=> (state == M_LEAD));
endmodule

// File: rtl/wpg_flags.sv
module wpg_flags #(
  parameter  int BLK_W   = 2,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               factory_init,
  input  logic               cycle_done,
  input  logic               arm,
  input  logic               arm_set,
  input  logic [BLK_W-1:0]   arm_blk,
  output logic [NUM_BLK-1:0] flags,
  output logic               pend_valid,
  output logic [BLK_W-1:0]   pend_blk
);
  logic pend_set;
  logic apply_now;

  assign apply_now = cycle_done && pend_valid;

  // Non-volatile flags: no connection to the normal reset
  always_ff @(posedge clk) begin
    if (factory_init)   flags <= '0;
    else if (apply_now) flags[pend_blk] <= pend_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_set   <= 1'b0;
      pend_blk   <= '0;
    end else if (arm) begin
      pend_valid <= 1'b1;
      pend_set   <= arm_set;
      pend_blk   <= arm_blk;
    end else if (cycle_done) begin
      pend_valid <= 1'b0;
    end
  end

  assert_flag_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_now && !factory_init) |=> (flags[$past(pend_blk)] == $past(pend_set)));

  assert_factory_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    factory_init |=> (flags == '0));

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply_now && !factory_init) |=> $stable(flags));
endmodule

// File: rtl/wpg_cmd_guard.sv
module wpg_cmd_guard
  import wpg_pkg::*;
#(
  parameter  int BLK_W   = 2,
  localparam int NUM_BLK = 1 << BLK_W,
  localparam int ADDR_W  = LOW_W + BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               factory_init,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               cycle_done,
  output logic               commit,
  output logic               timer_only,
  output logic [NUM_BLK-1:0] prot_flags
);
  logic             seq_byte, fin_protect, fin_release;
  logic             pend_valid;
  logic [BLK_W-1:0] pend_blk;
  logic [BLK_W-1:0] wr_blk;
  logic             window_open;
  logic             blk_locked;

  assign wr_blk = wr_addr[ADDR_W-1:LOW_W];

  wpg_matcher u_match (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_lo(wr_addr[LOW_W-1:0]), .wr_data(wr_data),
    .seq_byte(seq_byte), .fin_protect(fin_protect), .fin_release(fin_release)
  );

  wpg_flags #(.BLK_W(BLK_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .factory_init(factory_init), .cycle_done(cycle_done),
    .arm(fin_protect || fin_release), .arm_set(fin_protect), .arm_blk(wr_blk),
    .flags(prot_flags), .pend_valid(pend_valid), .pend_blk(pend_blk)
  );

  assign window_open = pend_valid && (pend_blk == wr_blk);
  assign blk_locked  = prot_flags[wr_blk] && !window_open;

  assign commit     = wr_valid && !seq_byte && !blk_locked;
  assign timer_only = wr_valid && ((!seq_byte && blk_locked) || fin_protect || fin_release);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, timer_only}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (!commit && !timer_only));
endmodule

// File: tb/tb_wpg_cmd_guard.sv
module tb_wpg_cmd_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        factory_init = 1'b1;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cycle_done = 1'b0;
  logic        commit, timer_only;
  logic [3:0]  prot_flags;

  always #5 clk = ~clk;

  wpg_cmd_guard dut (
    .clk(clk), .rst_n(rst_n), .factory_init(factory_init), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .cycle_done(cycle_done),
    .commit(commit), .timer_only(timer_only), .prot_flags(prot_flags)
  );

  int  n_chk = 0, n_fail = 0;
  bit  chk_on = 0, finished = 0;

  // behavioural reference
  bit [7:0]  sd [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
  bit [14:0] sa [6] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555};
  int        pos = 0;
  bit [3:0]  m_flags = '0;
  bit        m_pend = 0, m_pset = 0;
  bit [1:0]  m_pblk = '0;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on) check("R8 flags", prot_flags, m_flags);

  task automatic wr(input [16:0] a, input [7:0] d, input string req);
    bit c, t, fin, fs, seq, ok;
    int np;
    fin = 0; fs = 0; seq = 0; np = 0;
    if (pos == 2 && d == 8'hA0 && a[14:0] == 15'h5555) begin seq = 1; fin = 1; fs = 1; np = 0; end
    else if (d == sd[pos] && a[14:0] == sa[pos]) begin
      seq = 1; np = pos + 1;
      if (np == 6) begin fin = 1; fs = 0; np = 0; end
    end
    else if (d == 8'hAA && a[14:0] == 15'h5555) begin seq = 1; np = 1; end
    ok = !m_flags[a[16:15]] || (m_pend && m_pblk == a[16:15]);
    c = seq ? 1'b0 : ok;
    t = seq ? fin : !ok;
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    #2;
    check({req, " commit"}, {3'b0, commit}, {3'b0, c});
    check({req, " timer_only"}, {3'b0, timer_only}, {3'b0, t});
    @(posedge clk);
    pos = np;
    if (fin) begin m_pend = 1; m_pset = fs; m_pblk = a[16:15]; end
    #1 wr_valid = 0;
  endtask

  task automatic done_period();
    @(negedge clk); cycle_done = 1;
    @(posedge clk);
    if (m_pend) begin m_flags[m_pblk] = m_pset; m_pend = 0; end
    #1 cycle_done = 0;
  endtask

  task automatic protect(input [1:0] b);
    wr({b, 15'h5555}, 8'hAA, "R1");
    wr({b, 15'h2AAA}, 8'h55, "R1");
    wr({b, 15'h5555}, 8'hA0, "R6");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); factory_init = 0; rst_n = 1;
    chk_on = 1;
    check("R9 reset state", prot_flags, 4'b0000);
    // idle strobe
    @(negedge clk); #2;
    check("R10 idle", {2'b0, commit, timer_only}, 4'b0);
    wr(17'h00123, 8'h3C, "R5 open block");
    // R1: protect block1 with a data byte in its window (R4)
    protect(2'd1);
    wr(17'h08010, 8'h77, "R4 window");
    wr(17'h00010, 8'h11, "R8 other block");
    done_period();
    check("R1 set", prot_flags, 4'b0010);
    wr(17'h08020, 8'h99, "R5 locked");
    wr(17'h00020, 8'h98, "R8 block0 free");
    // R6: protect block3 with no data byte
    protect(2'd3);
    done_period();
    check("R6 no data", prot_flags, 4'b1010);
    // R4: protected block1 written after the sequence
    protect(2'd1);
    wr(17'h0C000, 8'h42, "R4 protected window");
    wr(17'h18000, 8'h43, "R8 block3 locked");
    done_period();
    // R7: broken sequence, then a repeated lead byte restarting it
    wr(17'h0D555, 8'hAA, "R3 lead");
    wr(17'h0C000, 8'h12, "R7 breaker");
    wr(17'h0AAAA, 8'h55, "R7 after break");
    wr(17'h05555, 8'hAA, "R3 lead");
    wr(17'h05555, 8'hAA, "R7 relead");
    wr(17'h02AAA, 8'h55, "R3 second");
    wr(17'h05555, 8'hA0, "R6 final");
    done_period();
    check("R7 restart", prot_flags, 4'b1011);
    // R2: release block1
    wr(17'h0D555, 8'hAA, "R2");
    wr(17'h0AAAA, 8'h55, "R2");
    wr(17'h0D555, 8'h80, "R2");
    wr(17'h0D555, 8'hAA, "R2");
    wr(17'h0AAAA, 8'h55, "R2");
    wr(17'h0D555, 8'h20, "R2 final");
    done_period();
    check("R2 clear", prot_flags, 4'b1001);
    wr(17'h08444, 8'h5A, "R2 released write");
    // R9: reset mid-sequence keeps flags and drops the partial match
    wr(17'h15555, 8'hAA, "R3 lead");
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; pos = 0; m_pend = 0;
    check("R9 after reset", prot_flags, 4'b1001);
    wr(17'h12AAA, 8'h55, "R9 stale second");
    wr(17'h15555, 8'hA0, "R9 stale third");
    done_period();
    check("R9 no change", prot_flags, 4'b1001);
    // factory clear
    @(negedge clk); factory_init = 1;
    @(posedge clk); m_flags = '0;
    #1 factory_init = 0;
    @(negedge clk);
    check("R9 factory", prot_flags, 4'b0000);
    wr(17'h18000, 8'h01, "R5 after factory");
    repeat (2) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule